// File: doc/BRIEF.md
# Slot-table memory arbiter

This block shares one memory port among fourteen requesting clients. A programmable table of sixty-four slots, each naming one client, sets the order in which clients get the port. A slot pointer walks the table. If the client named by the current slot is requesting, it gets the grant. If it is not, the slot goes to the requesting client with the lowest index. Bandwidth is shared out by how many slots name each client, and latency by how far apart those slots are spread.

The block holds two tables with two pointers and two grant outputs. One serves the external memory region and one serves the internal region. Each has its own request vector, and the two never affect each other. Software fills the tables one slot at a time through a small write port. How the table contents are computed is left to that software.

Top module: `tdm_mem_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, both grant outputs are zero and both slot pointers are at slot 0. Reset loads every slot s of both tables with client s mod 14, so slot 3 names client 3 and slot 17 names client 3.
- R2: Each grant output is one-hot or zero. A grant is only issued to a client whose request bit was high in the cycle the grant was decided.
- R3: A grant stays unchanged while the granted client keeps its request high. On the first clock edge after that request is seen low, the grant goes to zero.
- R4: When a grant is decided and the client named by the current slot is requesting, that client gets the grant, even if lower-index clients are also requesting.
- R5: When a grant is decided and the client named by the current slot is not requesting, the grant goes to the lowest-index requesting client. A slot that holds code 14 or 15 names no client and always uses this fallback.
- R6: The slot pointer of a region moves forward by one when a grant ends, and it wraps from slot 63 to slot 0.
- R7: While a region's grant is zero and none of its requests is high, no grant is issued and its slot pointer does not move.
- R8: A write with `cfg_we` high stores `cfg_client` into slot `cfg_slot` of the region chosen by `cfg_region` (0 = external, 1 = internal) on that clock edge. It changes no other slot and no slot of the other region. A write and a grant decision on the same edge use the slot contents from before the write.
- R9: The two regions arbitrate independently. Each one's grant depends only on its own requests, table and pointer.
- R10: On each clock edge where a region's grant is zero and at least one of its requests is high, a grant is issued on that edge. So there is exactly one idle cycle between the end of one grant and the start of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_region | input | 1 | Table select for a write: 0 = external, 1 = internal |
| cfg_slot | input | 6 | Slot number to write |
| cfg_client | input | 4 | Client code to store (14 and 15 mean no owner) |
| req_ext | input | 14 | Request vector for the external region, bit i = client i |
| req_int | input | 14 | Request vector for the internal region, bit i = client i |
| gnt_ext | output | 14 | One-hot grant for the external region |
| gnt_int | output | 14 | One-hot grant for the internal region |

## Verification
The properties make no assumption about how clients behave. A request may rise or fall in any cycle, whether the client is granted or not. The properties rely only on the request vectors and the write port being driven to known values in every cycle from reset onwards. The stimulus respects this by driving every input from time zero and changing inputs only on falling edges. The random phase then drops and raises requests at arbitrary points, including in the middle of a grant, so the hold and release rules are exercised under all orderings.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

   // Table selector carried on the write port.
   typedef enum logic {
      RGN_EXT = 1'b0,
      RGN_INT = 1'b1
   } rgn_e;

   localparam int unsigned RGN_COUNT = 2;

   // Picker implementation variants for the fallback path.
   localparam int unsigned PICK_CHAIN = 0;
   localparam int unsigned PICK_TWOS  = 1;

endpackage

// File: rtl/tdm_lowest_pick.sv
// Lowest-index one-hot selection out of a request vector.
module tdm_lowest_pick #(
   parameter int unsigned WIDTH = 14,
   parameter int unsigned STYLE = 0
) (
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] pick_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("tdm_lowest_pick: WIDTH must be at least 1");
      end
      if (STYLE > 1) begin : g_bad_style
         $error("tdm_lowest_pick: unknown STYLE");
      end

      if (STYLE == tdm_arb_pkg::PICK_CHAIN) begin : g_chain
         // Ripple chain: bit i wins when no lower bit is requesting.
         logic [WIDTH-1:0] lower_busy;
         assign lower_busy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign pick_o[i] = req_i[i] & ~lower_busy[i];
            if (i < WIDTH - 1) begin : g_link
               assign lower_busy[i+1] = lower_busy[i] | req_i[i];
            end
         end
      end else begin : g_twos
         // Two's complement isolate of the least significant set bit.
         assign pick_o = req_i & (~req_i + WIDTH'(1));
      end
   endgenerate

endmodule

// File: rtl/tdm_slot_table.sv
// Slot table for one region: one write port, one asynchronous read port.
module tdm_slot_table #(
   parameter int unsigned NUM_SLOTS   = 64,
   parameter int unsigned NUM_CLIENTS = 14,
   parameter int unsigned SLOT_W      = 6,
   parameter int unsigned CLIENT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [SLOT_W-1:0]   wr_slot_i,
   input  logic [CLIENT_W-1:0] wr_code_i,
   input  logic [SLOT_W-1:0]   rd_slot_i,
   output logic [CLIENT_W-1:0] rd_code_o
);

   logic [CLIENT_W-1:0] entry_q [NUM_SLOTS];

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_entry
         // Reset pattern spreads all clients evenly around the table.
         localparam logic [CLIENT_W-1:0] FILL = CLIENT_W'(s % NUM_CLIENTS);
         logic hit;
         assign hit = wr_en_i && (wr_slot_i == SLOT_W'(s));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               entry_q[s] <= FILL;
            end else if (hit) begin
               entry_q[s] <= wr_code_i;
            end
         end
      end
   endgenerate

   assign rd_code_o = entry_q[rd_slot_i];

endmodule

// File: rtl/tdm_grant_engine.sv
// Slot pointer and registered grant for one region.
module tdm_grant_engine #(
   parameter int unsigned NUM_CLIENTS = 14,
   parameter int unsigned NUM_SLOTS   = 64,
   parameter int unsigned SLOT_W      = 6,
   parameter int unsigned CLIENT_W    = 4,
   parameter int unsigned PICK_STYLE  = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CLIENTS-1:0] req_i,
   input  logic [CLIENT_W-1:0]    owner_i,
   output logic [SLOT_W-1:0]      slot_o,
   output logic [NUM_CLIENTS-1:0] gnt_o
);

   localparam bit SLOTS_POW2 = ((1 << SLOT_W) == NUM_SLOTS);

   logic [SLOT_W-1:0]      ptr_q;
   logic [SLOT_W-1:0]      ptr_next;
   logic [NUM_CLIENTS-1:0] gnt_q;
   logic [NUM_CLIENTS-1:0] owner_oh;
   logic [NUM_CLIENTS-1:0] fallback_oh;
   logic [NUM_CLIENTS-1:0] decided_oh;
   logic                   owner_claims;
   logic                   busy;
   logic                   finished;
   logic                   any_req;

   // Decode the slot code; codes at or above NUM_CLIENTS light no bit.
   generate
      for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_dec
         assign owner_oh[c] = (owner_i == CLIENT_W'(c));
      end
   endgenerate

   tdm_lowest_pick #(
      .WIDTH (NUM_CLIENTS),
      .STYLE (PICK_STYLE)
   ) u_pick (
      .req_i  (req_i),
      .pick_o (fallback_oh)
   );

   assign owner_claims = |(owner_oh & req_i);
   assign decided_oh   = owner_claims ? owner_oh : fallback_oh;
   assign any_req      = |req_i;
   assign busy         = |gnt_q;
   assign finished     = busy && !(|(gnt_q & req_i));

   // Pointer wrap: natural overflow for power-of-two tables, compare otherwise.
   generate
      if (SLOTS_POW2) begin : g_wrap_pow2
         assign ptr_next = ptr_q + SLOT_W'(1);
      end else begin : g_wrap_cmp
         assign ptr_next = (ptr_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + SLOT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         gnt_q <= '0;
      end else if (finished) begin
         gnt_q <= '0;
         ptr_q <= ptr_next;
      end else if (!busy && any_req) begin
         gnt_q <= decided_oh;
      end
   end

   assign slot_o = ptr_q;
   assign gnt_o  = gnt_q;

endmodule

// File: rtl/tdm_mem_arbiter.sv
// Two-region slot-table memory arbiter.
module tdm_mem_arbiter #(
   parameter int unsigned NUM_CLIENTS = 14,
   parameter int unsigned NUM_SLOTS   = 64,
   parameter int unsigned PICK_STYLE  = tdm_arb_pkg::PICK_CHAIN,
   localparam int unsigned CLIENT_W   = $clog2(NUM_CLIENTS + 1),
   localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic                   cfg_region,
   input  logic [SLOT_W-1:0]      cfg_slot,
   input  logic [CLIENT_W-1:0]    cfg_client,
   input  logic [NUM_CLIENTS-1:0] req_ext,
   input  logic [NUM_CLIENTS-1:0] req_int,
   output logic [NUM_CLIENTS-1:0] gnt_ext,
   output logic [NUM_CLIENTS-1:0] gnt_int
);

   import tdm_arb_pkg::*;

   localparam int unsigned NRGN = RGN_COUNT;

   generate
      if (NUM_CLIENTS < 2 || NUM_CLIENTS > 255) begin : g_bad_clients
         $error("tdm_mem_arbiter: NUM_CLIENTS out of range");
      end
      if (NUM_SLOTS < 2 || NUM_SLOTS > 4096) begin : g_bad_slots
         $error("tdm_mem_arbiter: NUM_SLOTS out of range");
      end
   endgenerate

   logic [NUM_CLIENTS-1:0] req_v   [NRGN];
   logic [NUM_CLIENTS-1:0] gnt_v   [NRGN];
   logic [NRGN-1:0]        wr_sel;

   assign req_v[int'(RGN_EXT)] = req_ext;
   assign req_v[int'(RGN_INT)] = req_int;
   assign gnt_ext = gnt_v[int'(RGN_EXT)];
   assign gnt_int = gnt_v[int'(RGN_INT)];

   generate
      for (genvar r = 0; r < NRGN; r++) begin : g_rgn
         logic [SLOT_W-1:0]   cur_slot;
         logic [CLIENT_W-1:0] cur_owner;

         assign wr_sel[r] = cfg_we && (cfg_region == rgn_e'(r));

         tdm_slot_table #(
            .NUM_SLOTS   (NUM_SLOTS),
            .NUM_CLIENTS (NUM_CLIENTS),
            .SLOT_W      (SLOT_W),
            .CLIENT_W    (CLIENT_W)
         ) u_table (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_sel[r]),
            .wr_slot_i (cfg_slot),
            .wr_code_i (cfg_client),
            .rd_slot_i (cur_slot),
            .rd_code_o (cur_owner)
         );

         tdm_grant_engine #(
            .NUM_CLIENTS (NUM_CLIENTS),
            .NUM_SLOTS   (NUM_SLOTS),
            .SLOT_W      (SLOT_W),
            .CLIENT_W    (CLIENT_W),
            .PICK_STYLE  (PICK_STYLE)
         ) u_engine (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_v[r]),
            .owner_i (cur_owner),
            .slot_o  (cur_slot),
            .gnt_o   (gnt_v[r])
         );
      end
   endgenerate

endmodule

// File: rtl/tdm_mem_arbiter_chk.sv
// Port-level properties of the arbiter, attached by bind.
module tdm_mem_arbiter_chk #(
   parameter int unsigned NUM_CLIENTS = 14
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_CLIENTS-1:0] req_ext,
   input logic [NUM_CLIENTS-1:0] req_int,
   input logic [NUM_CLIENTS-1:0] gnt_ext,
   input logic [NUM_CLIENTS-1:0] gnt_int
);

   // R2: at most one client holds each port
   p_onehot_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_ext));
   p_onehot_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_int));

   // R2: a fresh grant lands on a client that was requesting
   p_to_req_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ext == '0) |=> (gnt_ext == '0 || (gnt_ext & $past(req_ext)) != '0));
   p_to_req_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_int == '0) |=> (gnt_int == '0 || (gnt_int & $past(req_int)) != '0));

   // R3: grant held while the owner keeps requesting
   p_hold_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_ext & req_ext) != '0) |=> (gnt_ext == $past(gnt_ext)));
   p_hold_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_int & req_int) != '0) |=> (gnt_int == $past(gnt_int)));

   // R3: grant dropped one edge after the request falls
   p_release_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ext != '0 && (gnt_ext & req_ext) == '0) |=> (gnt_ext == '0));
   p_release_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_int != '0 && (gnt_int & req_int) == '0) |=> (gnt_int == '0));

   // R7: nothing is granted when nobody asks
   p_idle_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ext == '0 && req_ext == '0) |=> (gnt_ext == '0));
   p_idle_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_int == '0 && req_int == '0) |=> (gnt_int == '0));

   // R10: an idle port with a pending request grants on the next edge
   p_issue_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ext == '0 && req_ext != '0) |=> (gnt_ext != '0));
   p_issue_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_int == '0 && req_int != '0) |=> (gnt_int != '0));

endmodule

bind tdm_mem_arbiter tdm_mem_arbiter_chk #(
   .NUM_CLIENTS (NUM_CLIENTS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_ext (req_ext),
   .req_int (req_int),
   .gnt_ext (gnt_ext),
   .gnt_int (gnt_int)
);

// File: tb/tdm_mem_arbiter_tb.sv
`timescale 1ns/1ps
module tdm_mem_arbiter_tb;

   localparam int NC = 14;
   localparam int NS = 64;
   localparam logic [NC-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_region = 1'b0;
   logic [5:0]    cfg_slot = '0;
   logic [3:0]    cfg_client = '0;
   logic [NC-1:0] req_ext = '0;
   logic [NC-1:0] req_int = '0;
   logic [NC-1:0] gnt_ext;
   logic [NC-1:0] gnt_int;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // Reference state
   logic [3:0]    m_tbl [2][NS];
   int            m_ptr [2];
   logic [NC-1:0] m_gnt [2];

   always #2 clk = ~clk;

   tdm_mem_arbiter u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_region (cfg_region),
      .cfg_slot   (cfg_slot),
      .cfg_client (cfg_client),
      .req_ext    (req_ext),
      .req_int    (req_int),
      .gnt_ext    (gnt_ext),
      .gnt_int    (gnt_int)
   );

   function automatic logic [NC-1:0] lowest(input logic [NC-1:0] r);
      for (int i = 0; i < NC; i++) begin
         if (r[i]) return NC'(1) << i;
      end
      return '0;
   endfunction

   function automatic logic [NC-1:0] decide(input int rg, input logic [NC-1:0] r);
      int owner;
      owner = int'(m_tbl[rg][m_ptr[rg]]);
      if (owner < NC && r[owner]) return NC'(1) << owner;
      return lowest(r);
   endfunction

   task automatic model_reset();
      for (int rg = 0; rg < 2; rg++) begin
         for (int s = 0; s < NS; s++) m_tbl[rg][s] = 4'(s % NC);
         m_ptr[rg] = 0;
         m_gnt[rg] = '0;
      end
   endtask

   task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One clock: predict, clock, compare at the falling edge.
   task automatic step(input string tag);
      logic [NC-1:0] r [2];
      logic [NC-1:0] ng [2];
      int            np [2];
      r[0] = req_ext;
      r[1] = req_int;
      for (int rg = 0; rg < 2; rg++) begin
         ng[rg] = m_gnt[rg];
         np[rg] = m_ptr[rg];
         if (m_gnt[rg] != '0) begin
            if ((m_gnt[rg] & r[rg]) == '0) begin
               ng[rg] = '0;
               np[rg] = (m_ptr[rg] + 1) % NS;
            end
         end else if (r[rg] != '0) begin
            ng[rg] = decide(rg, r[rg]);
         end
      end
      @(posedge clk);
      for (int rg = 0; rg < 2; rg++) begin
         m_gnt[rg] = ng[rg];
         m_ptr[rg] = np[rg];
      end
      if (cfg_we) m_tbl[cfg_region][cfg_slot] = cfg_client;
      @(negedge clk);
      cfg_we = 1'b0;
      check({tag, " ext"}, gnt_ext, m_gnt[0]);
      check({tag, " int"}, gnt_int, m_gnt[1]);
   endtask

   task automatic do_reset();
      req_ext = '0;
      req_int = '0;
      cfg_we  = 1'b0;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      check("R1 reset ext", gnt_ext, '0);
      check("R1 reset int", gnt_int, '0);
      rst_n = 1'b1;
   endtask

   task automatic write_slot(input logic rg, input int slot, input int code);
      cfg_we     = 1'b1;
      cfg_region = rg;
      cfg_slot   = 6'(slot);
      cfg_client = 4'(code);
      step("R8 write");
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R10 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int client;
      do_reset();
      @(negedge clk);

      // R10 and R5: owner of slot 0 (client 0) idle, lowest of {3,7} wins at once
      req_ext = NC'(14'h0088);
      step("R10 first grant");
      check("R5 fallback to 3", gnt_ext, NC'(14'h0008));
      step("R3 hold");
      step("R3 hold");
      check("R3 held", gnt_ext, NC'(14'h0008));
      req_ext = NC'(14'h0080);
      step("R3 release");
      check("R3 released", gnt_ext, '0);
      step("R5 next");
      check("R5 slot1 owner idle", gnt_ext, NC'(14'h0080));
      req_ext = '0;
      step("R3 release");

      // R7: long idle must not move the pointer (now at slot 2)
      for (int i = 0; i < 10; i++) begin
         step("R7 idle");
         check("R7 no grant", gnt_ext, '0);
      end
      req_ext = NC'(14'h0005);
      step("R4 owner");
      check("R4 owner 2 beats client 0", gnt_ext, NC'(14'h0004));
      req_ext = '0;
      step("R3 release");

      // R8 and R9: retarget ext slot 3; int table stays as reset
      write_slot(1'b0, 3, 9);
      req_ext = NC'(14'h0202);
      req_int = NC'(14'h020A);
      step("R9 both");
      check("R8 written owner 9", gnt_ext, NC'(14'h0200));
      check("R9 int untouched", gnt_int, NC'(14'h0002));
      req_ext = '0;
      req_int = '0;
      step("R3 release");

      // R5: code 15 in ext slot 4 owns nothing
      write_slot(1'b0, 4, 15);
      req_ext = NC'(14'h3000);
      step("R5 invalid code");
      check("R5 invalid owner fallback", gnt_ext, NC'(14'h1000));
      req_ext = '0;
      step("R3 release");

      // R1 and R6: fresh reset, everyone requests, 70 grants cross the wrap
      do_reset();
      @(negedge clk);
      for (int k = 0; k < 70; k++) begin
         req_ext = ALL;
         req_int = ALL;
         step("R6 grant");
         client = (k < NS) ? (k % NC) : ((k - NS) % NC);
         check("R6 slot order ext", gnt_ext, NC'(1) << client);
         check("R6 slot order int", gnt_int, NC'(1) << client);
         req_ext = ALL & ~gnt_ext;
         req_int = ALL & ~gnt_int;
         step("R6 release");
      end
      req_ext = '0;
      req_int = '0;
      step("R7 idle");

      // Random phase checked against the reference
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(5) == 0) begin
            cfg_we     = 1'b1;
            cfg_region = 1'($urandom_range(1));
            cfg_slot   = 6'($urandom_range(NS - 1));
            cfg_client = 4'($urandom_range(15));
         end
         req_ext = NC'($urandom & $urandom);
         req_int = NC'($urandom & $urandom & $urandom);
         step("R2_R4_R5 random");
         n_tests++;
         if ($countones(gnt_ext) > 1 || $countones(gnt_int) > 1) begin
            n_fail++;
            $display("FAIL R2 onehot: actual %h/%h expected at most one bit", gnt_ext, gnt_int);
         end
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule